// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a small processor built around one 16-bit accumulator. It runs a fetch, decode and execute loop over a unified, word-addressed memory of 4096 words of 16 bits each. Every instruction word holds a 4-bit operation code in bits 15..12 and a 12-bit operand address in bits 11..0. Data is two's complement, and arithmetic wraps modulo 2^16 with no overflow flag. Branches are either unconditional jumps or a conditional skip. The skip tests the sign of the accumulator and, when the test is true, steps over the following instruction.

The processor reaches memory through a synchronous port. A read is requested with `mem_re` and its data arrives one cycle later. A write is requested with `mem_we` and takes effect at the clock edge. Byte-wide input and output ports use valid/ready handshakes, and the processor stalls until each transfer completes. A halt instruction stops all further activity until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it, the processor fetches from address 0. In that state `halted`, `out_valid` and `in_ready` are low.
- R2: Each fetch reads the word at the program counter, and the counter then advances by 1 modulo 4096, so a fetch at 0xFFF is followed by a fetch at 0x000.
- R3: Operation 1 (load) reads memory at the operand address and places that word in the accumulator.
- R4: Operation 3 (add) and operation 4 (subtract) read memory at the operand address. They replace the accumulator with the accumulator plus or minus that word, modulo 2^16.
- R5: Operation 2 (store) writes the accumulator to memory at the operand address.
- R6: Operation 8 (skip) looks at bits 11..10. The code 00 skips when the accumulator is negative, 01 skips when it is zero, 10 skips when it is positive and non-zero, and 11 never skips. A skip steps the program counter past the next instruction.
- R7: Operation 9 (jump) continues at the operand address. Operation 0 (jump-and-store) writes the return address, which is the address of the next instruction zero-extended to 16 bits, to the operand address, and then continues at the operand address plus 1.
- R8: Operation 10 (clear) sets the accumulator to zero.
- R9: Operation 5 (input) holds `in_ready` high until `in_valid` is seen. It then loads the 8-bit input value, zero-extended, into the accumulator.
- R10: Operation 6 (output) presents the low 8 bits of the accumulator on `out_data`. `out_valid` stays high, with the data stable, until `out_ready` is seen, and exactly one transfer takes place.
- R11: Operation 7 (halt) raises `halted`, which stays high until reset. While halted the processor makes no memory read or write.
- R12: Operation codes 11 to 15 change neither the accumulator nor memory, and execution continues with the next instruction.
- R13: Read data is taken one cycle after `mem_re`. `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address |
| mem_re | output | 1 | Memory read request; data is expected on the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |
| in_data | input | 8 | Input port byte |
| in_valid | input | 1 | Input byte is available |
| in_ready | output | 1 | Processor is waiting for an input byte |
| out_data | output | 8 | Output port byte |
| out_valid | output | 1 | Output byte is presented |
| out_ready | input | 1 | Consumer accepts the output byte |
| halted | output | 1 | Processor has executed halt |

## Verification
The bench builds the processor with its default widths: a 12-bit address, a 16-bit data word and an 8-bit input/output byte. It places a 256-word memory behind the port and adds one extra word decoded at address 0xFFF. The 8-bit input width makes a full sweep of all 256 input bytes possible. The add, subtract and skip checks cross a set of operands that includes 0, 1, 0x7FFF, 0x8000 and 0xFFFF with every skip code. The extra word at 0xFFF lets the bench watch the program counter wrap to zero.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned IO_W   = 8;
    localparam int unsigned OPC_W  = 4;

    localparam logic [OPC_W-1:0] OP_JNS   = 4'h0;
    localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'h3;
    localparam logic [OPC_W-1:0] OP_SUB   = 4'h4;
    localparam logic [OPC_W-1:0] OP_IN    = 4'h5;
    localparam logic [OPC_W-1:0] OP_OUT   = 4'h6;
    localparam logic [OPC_W-1:0] OP_HALT  = 4'h7;
    localparam logic [OPC_W-1:0] OP_SKIP  = 4'h8;
    localparam logic [OPC_W-1:0] OP_JUMP  = 4'h9;
    localparam logic [OPC_W-1:0] OP_CLR   = 4'hA;

    typedef enum logic [2:0] {
        ACC_KEEP, ACC_LOAD, ACC_ADD, ACC_SUB, ACC_CLR, ACC_IN
    } acc_op_e;

    typedef enum logic [1:0] {
        SK_NEG = 2'b00, SK_ZERO = 2'b01, SK_POS = 2'b10, SK_NEVER = 2'b11
    } skip_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_LATCH, ST_DISP, ST_OPWAIT, ST_APPLY,
        ST_INWAIT, ST_OUTWAIT, ST_HALT
    } state_e;

    function automatic logic needs_operand(input logic [OPC_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DW = acc_cpu_pkg::DATA_W,
    parameter int unsigned IW = acc_cpu_pkg::IO_W
) (
    input  acc_op_e         op,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   mbr,
    input  logic [IW-1:0]   in_byte,
    output logic [DW-1:0]   acc_next
);
    always_comb begin
        case (op)
            ACC_LOAD: acc_next = mbr;
            ACC_ADD:  acc_next = acc + mbr;
            ACC_SUB:  acc_next = acc - mbr;
            ACC_CLR:  acc_next = '0;
            ACC_IN:   acc_next = DW'(in_byte);
            default:  acc_next = acc;
        endcase
    end
endmodule

// File: rtl/acc_cpu_skip.sv
module acc_cpu_skip
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DW = acc_cpu_pkg::DATA_W
) (
    input  logic [DW-1:0] acc,
    input  logic [1:0]    cond,
    output logic          take
);
    logic neg, zero;
    assign neg  = acc[DW-1];
    assign zero = (acc == '0);

    always_comb begin
        case (skip_e'(cond))
            SK_NEG:  take = neg;
            SK_ZERO: take = zero;
            SK_POS:  take = !neg && !zero;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int unsigned AW = acc_cpu_pkg::ADDR_W,
    parameter int unsigned DW = acc_cpu_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] mem_rdata,
    input  logic          skip_take,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic          wr_pc,
    output acc_op_e       acc_op,
    output logic          mbr_en,
    output logic          out_en,
    output logic          in_ready,
    output logic          out_valid,
    output logic          halted,
    output logic [AW-1:0] pc_q,
    output logic [1:0]    skip_cond
);
    localparam int unsigned OPC_LSB = DW - OPC_W;

    state_e          st_q, st_d;
    logic [AW-1:0]   pc_d, mar_q, mar_d;
    logic [DW-1:0]   ir_q, ir_d;
    logic [OPC_W-1:0] opc;

    assign opc       = ir_q[DW-1:OPC_LSB];
    assign skip_cond = ir_q[AW-1:AW-2];

    always_comb begin
        st_d      = st_q;
        pc_d      = pc_q;
        mar_d     = mar_q;
        ir_d      = ir_q;
        mem_addr  = pc_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        wr_pc     = 1'b0;
        acc_op    = ACC_KEEP;
        mbr_en    = 1'b0;
        out_en    = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        halted    = 1'b0;
        case (st_q)
            ST_FETCH: begin
                mem_re = 1'b1;
                st_d   = ST_LATCH;
            end
            ST_LATCH: begin
                ir_d  = mem_rdata;
                mar_d = mem_rdata[AW-1:0];
                pc_d  = pc_q + 1'b1;
                st_d  = ST_DISP;
            end
            ST_DISP: begin
                st_d = ST_FETCH;
                if (needs_operand(opc)) begin
                    mem_addr = mar_q;
                    mem_re   = 1'b1;
                    st_d     = ST_OPWAIT;
                end else begin
                    case (opc)
                        OP_STORE: begin
                            mem_addr = mar_q;
                            mem_we   = 1'b1;
                        end
                        OP_JNS: begin
                            mem_addr = mar_q;
                            mem_we   = 1'b1;
                            wr_pc    = 1'b1;
                            pc_d     = mar_q + 1'b1;
                        end
                        OP_JUMP: pc_d = mar_q;
                        OP_CLR:  acc_op = ACC_CLR;
                        OP_SKIP: if (skip_take) pc_d = pc_q + 1'b1;
                        OP_IN:   st_d = ST_INWAIT;
                        OP_OUT: begin
                            out_en = 1'b1;
                            st_d   = ST_OUTWAIT;
                        end
                        OP_HALT: st_d = ST_HALT;
                        default: st_d = ST_FETCH;
                    endcase
                end
            end
            ST_OPWAIT: begin
                mbr_en = 1'b1;
                st_d   = ST_APPLY;
            end
            ST_APPLY: begin
                case (opc)
                    OP_ADD:  acc_op = ACC_ADD;
                    OP_SUB:  acc_op = ACC_SUB;
                    default: acc_op = ACC_LOAD;
                endcase
                st_d = ST_FETCH;
            end
            ST_INWAIT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    acc_op = ACC_IN;
                    st_d   = ST_FETCH;
                end
            end
            ST_OUTWAIT: begin
                out_valid = 1'b1;
                if (out_ready) st_d = ST_FETCH;
            end
            default: halted = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_FETCH;
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
        end else begin
            st_q  <= st_d;
            pc_q  <= pc_d;
            mar_q <= mar_d;
            ir_q  <= ir_d;
        end
    end

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R13
    AST_LATCH_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LATCH) |-> $past(mem_re)); // R13
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LATCH) |=> (pc_q == AW'($past(pc_q) + 1'b1))); // R2
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R11
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_re && !mem_we)); // R11
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned AW = acc_cpu_pkg::ADDR_W,
    parameter int unsigned DW = acc_cpu_pkg::DATA_W,
    parameter int unsigned IW = acc_cpu_pkg::IO_W
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic [IW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [IW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          halted
);
    logic [DW-1:0] acc_q, acc_d, mbr_q;
    logic [IW-1:0] outreg_q;
    logic [AW-1:0] pc;
    logic [1:0]    skip_cond;
    logic          skip_take, wr_pc, mbr_en, out_en;
    acc_op_e       acc_op;

    acc_cpu_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .skip_take(skip_take),
        .in_valid(in_valid), .out_ready(out_ready), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .wr_pc(wr_pc), .acc_op(acc_op),
        .mbr_en(mbr_en), .out_en(out_en), .in_ready(in_ready),
        .out_valid(out_valid), .halted(halted), .pc_q(pc),
        .skip_cond(skip_cond)
    );

    acc_cpu_alu #(.DW(DW), .IW(IW)) u_alu (
        .op(acc_op), .acc(acc_q), .mbr(mbr_q), .in_byte(in_data),
        .acc_next(acc_d)
    );

    acc_cpu_skip #(.DW(DW)) u_skip (
        .acc(acc_q), .cond(skip_cond), .take(skip_take)
    );

    assign mem_wdata = wr_pc ? DW'(pc) : acc_q;
    assign out_data  = outreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            mbr_q    <= '0;
            outreg_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (mbr_en) mbr_q    <= mem_rdata;
            if (out_en) outreg_q <= acc_q[IW-1:0];
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
    AST_IN_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (acc_q[DW-1:IW] == '0)); // R9
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_op == ACC_CLR) |=> (acc_q == '0)); // R8
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [7:0]  in_data = 8'h0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        halted;

    logic [15:0] mem [0:255];
    logic [15:0] top_word;
    int total = 0;
    int bad = 0;
    int cycles = 0;
    int both_cnt = 0;
    int out_xfers = 0;

    acc_cpu u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .halted(halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_re && mem_we) both_cnt <= both_cnt + 1;
        if (!rst && out_valid && out_ready) out_xfers <= out_xfers + 1;
        if (mem_we && mem_addr < 12'd256) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) begin
            if (mem_addr == 12'hFFF)     mem_rdata <= top_word;
            else if (mem_addr < 12'd256) mem_rdata <= mem[mem_addr[7:0]];
            else                         mem_rdata <= 16'h0;
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        top_word = 16'h0;
    endtask

    task automatic go();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input string req);
        int n;
        n = 0;
        while (!halted && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'h0, halted}, 32'h1);
    endtask

    function automatic logic [15:0] pick(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            default: return 16'(k * 40503) ^ 16'h0F0F;
        endcase
    endfunction

    initial begin
        // R1: reset state
        begin_prog();
        check("R1 halted", {31'h0, halted}, 32'h0);
        check("R1 out_valid", {31'h0, out_valid}, 32'h0);
        check("R1 in_ready", {31'h0, in_ready}, 32'h0);
        check("R1 first fetch", {19'h0, mem_re, mem_addr}, {19'h0, 1'b1, 12'h000});

        // R3 R4 R5: add/subtract sweep (load, op, store, halt)
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [15:0] a, b, e;
                    a = pick(i);
                    b = pick(j);
                    e = (s == 0) ? a + b : a - b;
                    begin_prog();
                    mem[0] = 16'h1010;
                    mem[1] = (s == 0) ? 16'h3011 : 16'h4011;
                    mem[2] = 16'h2012;
                    mem[3] = 16'h7000;
                    mem[8'h10] = a;
                    mem[8'h11] = b;
                    go();
                    run_to_halt("R11 arith halt");
                    check(s == 0 ? "R4 add (R3 load, R5 store)" : "R4 sub (R3 load, R5 store)",
                          {16'h0, mem[8'h12]}, {16'h0, e});
                end
            end
        end

        // R6: skip over every code and operand
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 8; i++) begin
                logic [15:0] a;
                logic take;
                a = pick(i);
                case (c)
                    0: take = a[15];
                    1: take = (a == 16'h0);
                    2: take = !a[15] && (a != 16'h0);
                    default: take = 1'b0;
                endcase
                begin_prog();
                mem[0] = 16'h1010;
                mem[1] = 16'h8000 | 16'(c << 10);
                mem[2] = 16'h7000;
                mem[3] = 16'hA000;
                mem[4] = 16'h2012;
                mem[5] = 16'h7000;
                mem[8'h10] = a;
                mem[8'h12] = 16'hBEEF;
                go();
                run_to_halt("R11 skip halt");
                check("R6 skip", {16'h0, mem[8'h12]}, take ? 32'h0 : 32'hBEEF);
            end
        end

        // R7: jump
        begin_prog();
        mem[0] = 16'h9005;
        mem[1] = 16'h7000;
        mem[5] = 16'h1010;
        mem[6] = 16'h2012;
        mem[7] = 16'h7000;
        mem[8'h10] = 16'h1234;
        mem[8'h12] = 16'hBEEF;
        go();
        run_to_halt("R11 jump halt");
        check("R7 jump", {16'h0, mem[8'h12]}, 32'h1234);

        // R7: jump-and-store from address 0 and from address 3
        begin_prog();
        mem[0] = 16'h0020;
        mem[8'h21] = 16'h7000;
        go();
        run_to_halt("R7 jns halt");
        check("R7 jns return", {16'h0, mem[8'h20]}, 32'h0001);

        begin_prog();
        mem[0] = 16'h9003;
        mem[3] = 16'h0040;
        mem[8'h41] = 16'h7000;
        go();
        run_to_halt("R7 jns2 halt");
        check("R7 jns return2", {16'h0, mem[8'h40]}, 32'h0004);

        // R8: clear
        begin_prog();
        mem[0] = 16'h1010;
        mem[1] = 16'hA000;
        mem[2] = 16'h2012;
        mem[3] = 16'h7000;
        mem[8'h10] = 16'hFFFF;
        mem[8'h12] = 16'hBEEF;
        go();
        run_to_halt("R8 clear halt");
        check("R8 clear", {16'h0, mem[8'h12]}, 32'h0);

        // R9: every input byte, zero-extended
        for (int v = 0; v < 256; v++) begin
            int n;
            begin_prog();
            mem[0] = 16'h5000;
            mem[1] = 16'h2012;
            mem[2] = 16'h7000;
            mem[8'h12] = 16'hFFFF;
            go();
            n = 0;
            while (!in_ready && n < 50) begin
                @(negedge clk);
                n++;
            end
            if (v == 0) begin
                repeat (3) @(negedge clk);
                check("R9 waits for valid", {30'h0, in_ready, mem_we}, {30'h0, 1'b1, 1'b0});
            end
            in_data = 8'(v);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            run_to_halt("R9 input halt");
            check("R9 input", {16'h0, mem[8'h12]}, 32'(v));
        end

        // R10: output holds until accepted, one transfer
        begin_prog();
        mem[0] = 16'h1010;
        mem[1] = 16'h6000;
        mem[2] = 16'h7000;
        mem[8'h10] = 16'h12C3;
        go();
        begin
            int n;
            n = 0;
            while (!out_valid && n < 50) begin
                @(negedge clk);
                n++;
            end
        end
        check("R10 out data", {24'h0, out_data}, 32'hC3);
        repeat (4) @(negedge clk);
        check("R10 held", {22'h0, out_valid, halted, out_data}, {22'h0, 1'b1, 1'b0, 8'hC3});
        out_xfers = 0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        run_to_halt("R10 out halt");
        check("R10 one transfer", {31'h0, out_valid}, 32'h0);
        check("R10 xfer count", 32'(out_xfers), 32'd1);

        // R11: halted stays quiet
        begin
            int act;
            act = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (mem_re || mem_we || !halted) act++;
            end
            check("R11 quiet after halt", 32'(act), 32'd0);
        end

        // R12: unused codes leave acc and memory alone
        for (int op = 11; op < 16; op++) begin
            begin_prog();
            mem[0] = 16'h1010;
            mem[1] = 16'(op << 12) | 16'h013;
            mem[2] = 16'h2012;
            mem[3] = 16'h7000;
            mem[8'h10] = 16'h3C5A + 16'(op);
            mem[8'h13] = 16'h5555;
            go();
            run_to_halt("R12 nop halt");
            check("R12 acc unchanged", {16'h0, mem[8'h12]}, {16'h0, 16'h3C5A + 16'(op)});
            check("R12 memory untouched", {16'h0, mem[8'h13]}, 32'h5555);
        end

        // R2: program counter wraps from 0xFFF to 0x000
        begin_prog();
        mem[0] = 16'h9FFF;
        top_word = 16'hA000;
        go();
        begin
            int n;
            logic [11:0] next_addr;
            n = 0;
            while (!(mem_re && mem_addr == 12'hFFF) && n < 50) begin
                @(negedge clk);
                n++;
            end
            @(negedge clk);
            n = 0;
            while (!mem_re && n < 50) begin
                @(negedge clk);
                n++;
            end
            next_addr = mem_addr;
            check("R2 pc wrap", {20'h0, next_addr}, 32'h000);
        end

        // R13: read and write never together
        check("R13 rw exclusive", 32'(both_cnt), 32'd0);

        finish_run();
    end
endmodule